// File: doc/BRIEF.md
# Multi-Master Hardware Semaphore Bank

This block gives the processors of a chip a shared set of ownership flags. There are 32 semaphores, each behind its own 32-bit register. To claim one, a master writes any nonzero value to that semaphore's register while presenting its own identity on a 4-bit sideband. It then reads the register back. The claim has succeeded only if the low nibble it reads equals its own identity. The owner gives the semaphore up by writing zero to the same register.

The block has several register ports, one per master. Each port has an address, a write enable, write data, a master-ID sideband and read data. Reads are combinational and show the state as it stands before the writes of the current cycle. Writes take effect at the next rising clock edge. Two registers sit beside the semaphores. The first is a control register whose bit 0 selects the signalling protocol; zero means polled operation with no interrupts. The second is a clear-all register. A write to it is passed on as a one-cycle clear strobe to the interrupt logic outside the block.

Top module: `hsem_bank`

## Requirements
- R1: Semaphore i is at byte offset 0x08 + 4*i, for i from 0 to 31. Reading it returns the owner identity in bits [3:0] and zeros in all other bits. A free semaphore reads as 0.
- R2: A write of nonzero data to a free semaphore by a master with identity m (1 to 15) makes m the owner from the next cycle on.
- R3: A write of nonzero data to a semaphore that is held is ignored, whoever makes it, and the owner is unchanged.
- R4: A write of zero releases a held semaphore only when the writer's identity equals the owner. A release attempt from any other identity is ignored.
- R5: When several ports claim the same free semaphore in one cycle, the lowest identity among them becomes the owner.
- R6: Every write that presents master identity 0 is ignored at the semaphore registers.
- R7: The control register is at offset 0x00. Only bit 0 is stored; it reads back in bit 0, other bits read 0, and it drives proto_mode. When several ports write it in one cycle, the lowest-numbered port wins.
- R8: A write to offset 0x90 drives irq_clear with bits [15:0] of the write data for exactly the following cycle (0xFFFF clears everything), ORed across ports. irq_clear is 0 otherwise, and offset 0x90 reads as 0.
- R9: After reset all semaphores are free, the control register is 0 and irq_clear is 0.
- R10: Offsets that map to nothing, including misaligned semaphore offsets, read as 0, and writes to them change no state.
- R11: If the owner releases a semaphore while another master claims it in the same cycle, the semaphore is free in the next cycle.
- R12: Each port's read data is combinational and reflects the state before that cycle's writes. Every port can read any register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | NUM_PORT x ADDR_W | Byte offset per port |
| bus_we | input | NUM_PORT | Write enable per port |
| bus_wdata | input | NUM_PORT x DATA_W | Write data per port |
| bus_mid | input | NUM_PORT x ID_W | Master identity presented by each port |
| bus_rdata | output | NUM_PORT x DATA_W | Combinational read data per port |
| proto_mode | output | 1 | Protocol-select bit of the control register |
| irq_clear | output | CLR_W | One-cycle clear strobe for external interrupt status |

## Verification
The hardest states to reach are the ones that need two ports to hit the same semaphore in the same cycle. Examples are two claims with the higher identity on the lower port, and a release by the owner together with a claim from someone else. The bench drives both ports in one cycle for these cases. It then runs a long random phase over a small set of addresses and identities, so that such collisions come up often. Every read port and output is compared against a behavioural model on every clock.

// File: rtl/hsem_pkg.sv
package hsem_pkg;

    typedef enum logic [1:0] {
        ACC_NONE,
        ACC_CTRL,
        ACC_SEM,
        ACC_ICR
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e   kind;
        logic [15:0] idx;
    } acc_t;

    localparam int CTRL_OFS     = 'h00;
    localparam int SEM_BASE_OFS = 'h08;
    localparam int SEM_STRIDE   = 4;
    localparam int ICR_OFS      = 'h90;

    function automatic acc_t classify(input logic [31:0] ofs, input int num_sem);
        acc_t r;
        r.kind = ACC_NONE;
        r.idx  = '0;
        if (ofs == 32'(CTRL_OFS)) begin
            r.kind = ACC_CTRL;
        end else if (ofs == 32'(ICR_OFS)) begin
            r.kind = ACC_ICR;
        end else if (ofs >= 32'(SEM_BASE_OFS) &&
                     ofs < 32'(SEM_BASE_OFS + SEM_STRIDE * num_sem) &&
                     ofs[1:0] == 2'b00) begin
            r.kind = ACC_SEM;
            r.idx  = 16'((ofs - 32'(SEM_BASE_OFS)) >> 2);
        end
        return r;
    endfunction

endpackage

// File: rtl/hsem_decode.sv
module hsem_decode
    import hsem_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int NUM_SEM = 32
) (
    input  logic [ADDR_W-1:0] addr,
    output acc_t              acc
);
    logic [31:0] ofs;

    always_comb begin
        ofs = 32'(addr);
        acc = classify(ofs, NUM_SEM);
    end
endmodule

// File: rtl/hsem_cell.sv
module hsem_cell #(
    parameter int NUM_PORT = 2,
    parameter int ID_W     = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PORT-1:0]           claim_v,
    input  logic [NUM_PORT-1:0]           rel_v,
    input  logic [NUM_PORT-1:0][ID_W-1:0] req_id,
    output logic [ID_W-1:0]               owner_o
);
    logic [ID_W-1:0] owner_q, owner_d, best_id;
    logic            found, release_hit;

    // lowest identity among claimers
    always_comb begin
        best_id = '1;
        found   = 1'b0;
        for (int p = 0; p < NUM_PORT; p++) begin
            if (claim_v[p] && (!found || req_id[p] < best_id)) begin
                best_id = req_id[p];
                found   = 1'b1;
            end
        end
    end

    always_comb begin
        release_hit = 1'b0;
        for (int p = 0; p < NUM_PORT; p++) begin
            if (rel_v[p] && req_id[p] == owner_q) release_hit = 1'b1;
        end
    end

    always_comb begin
        owner_d = owner_q;
        if (owner_q != '0) begin
            if (release_hit) owner_d = '0;
        end else if (found) begin
            owner_d = best_id;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) owner_q <= '0;
        else     owner_q <= owner_d;
    end

    assign owner_o = owner_q;

    // held semaphore never passes straight to another master
    assert_no_takeover_R3: assert property (@(posedge clk) disable iff (rst)
        (owner_q != '0) |=> (owner_q == $past(owner_q) || owner_q == '0));

    // nothing frees a held semaphore unless a release request arrives
    assert_release_needs_request_R4: assert property (@(posedge clk) disable iff (rst)
        (owner_q != '0 && rel_v == '0) |=> $stable(owner_q));

    // free semaphore with no claimers stays free
    assert_free_stays_free_R2: assert property (@(posedge clk) disable iff (rst)
        (owner_q == '0 && claim_v == '0) |=> (owner_q == '0));

    // a claim on a free semaphore always lands on one claimer
    assert_claim_lands_R5: assert property (@(posedge clk) disable iff (rst)
        (owner_q == '0 && claim_v != '0) |=> (owner_q != '0));
endmodule

// File: rtl/hsem_ctrl.sv
module hsem_ctrl #(
    parameter int NUM_PORT = 2,
    parameter int CLR_W    = 16
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NUM_PORT-1:0]            ctrl_we,
    input  logic [NUM_PORT-1:0]            ctrl_bit,
    input  logic [NUM_PORT-1:0]            icr_we,
    input  logic [NUM_PORT-1:0][CLR_W-1:0] icr_mask,
    output logic                           proto_q,
    output logic [CLR_W-1:0]               clr_q
);
    logic             proto_d;
    logic [CLR_W-1:0] clr_d;

    always_comb begin
        proto_d = proto_q;
        // walk downward so the lowest port is applied last and wins
        for (int p = NUM_PORT - 1; p >= 0; p--) begin
            if (ctrl_we[p]) proto_d = ctrl_bit[p];
        end
        clr_d = '0;
        for (int p = 0; p < NUM_PORT; p++) begin
            if (icr_we[p]) clr_d = clr_d | icr_mask[p];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            proto_q <= 1'b0;
            clr_q   <= '0;
        end else begin
            proto_q <= proto_d;
            clr_q   <= clr_d;
        end
    end

    assert_clear_one_shot_R8: assert property (@(posedge clk) disable iff (rst)
        (icr_we == '0) |=> (clr_q == '0));

    assert_ctrl_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (ctrl_we == '0) |=> $stable(proto_q));
endmodule

// File: rtl/hsem_bank.sv
module hsem_bank
    import hsem_pkg::*;
#(
    parameter int NUM_SEM  = 32,
    parameter int NUM_PORT = 2,
    parameter int ADDR_W   = 8,
    parameter int DATA_W   = 32,
    parameter int ID_W     = 4,
    parameter int CLR_W    = 16
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_PORT-1:0][ADDR_W-1:0]  bus_addr,
    input  logic [NUM_PORT-1:0]              bus_we,
    input  logic [NUM_PORT-1:0][DATA_W-1:0]  bus_wdata,
    input  logic [NUM_PORT-1:0][ID_W-1:0]    bus_mid,
    output logic [NUM_PORT-1:0][DATA_W-1:0]  bus_rdata,
    output logic                             proto_mode,
    output logic [CLR_W-1:0]                 irq_clear
);
    acc_t                            acc [NUM_PORT];
    logic [NUM_PORT-1:0]             wr_sem_claim, wr_sem_rel;
    logic [ID_W-1:0]                 owner [NUM_SEM];
    logic [NUM_PORT-1:0]             ctrl_we, ctrl_bit, icr_we;
    logic [NUM_PORT-1:0][CLR_W-1:0]  icr_mask;

    // per-port decode and write qualification
    for (genvar p = 0; p < NUM_PORT; p++) begin : g_port
        hsem_decode #(.ADDR_W(ADDR_W), .NUM_SEM(NUM_SEM)) u_dec (
            .addr (bus_addr[p]),
            .acc  (acc[p])
        );

        always_comb begin
            wr_sem_claim[p] = bus_we[p] && acc[p].kind == ACC_SEM &&
                              bus_mid[p] != '0 && bus_wdata[p] != '0;
            wr_sem_rel[p]   = bus_we[p] && acc[p].kind == ACC_SEM &&
                              bus_mid[p] != '0 && bus_wdata[p] == '0;
            ctrl_we[p]      = bus_we[p] && acc[p].kind == ACC_CTRL;
            ctrl_bit[p]     = bus_wdata[p][0];
            icr_we[p]       = bus_we[p] && acc[p].kind == ACC_ICR;
            icr_mask[p]     = bus_wdata[p][CLR_W-1:0];
        end

        // read mux: current state, before this cycle's writes
        always_comb begin
            bus_rdata[p] = '0;
            case (acc[p].kind)
                ACC_CTRL: bus_rdata[p] = DATA_W'(proto_mode);
                ACC_SEM: begin
                    for (int s = 0; s < NUM_SEM; s++) begin
                        if (acc[p].idx == 16'(s)) bus_rdata[p] = DATA_W'(owner[s]);
                    end
                end
                default: bus_rdata[p] = '0;
            endcase
        end

        assert_unmapped_reads_zero_R10: assert property (@(posedge clk) disable iff (rst)
            (acc[p].kind == ACC_NONE || acc[p].kind == ACC_ICR) |-> (bus_rdata[p] == '0));

        assert_sem_upper_zero_R1: assert property (@(posedge clk) disable iff (rst)
            (acc[p].kind == ACC_SEM) |-> (bus_rdata[p][DATA_W-1:ID_W] == '0));
    end

    // one arbitration cell per semaphore
    for (genvar s = 0; s < NUM_SEM; s++) begin : g_sem
        logic [NUM_PORT-1:0] claim_v, rel_v;

        always_comb begin
            for (int p = 0; p < NUM_PORT; p++) begin
                claim_v[p] = wr_sem_claim[p] && acc[p].idx == 16'(s);
                rel_v[p]   = wr_sem_rel[p]   && acc[p].idx == 16'(s);
            end
        end

        hsem_cell #(.NUM_PORT(NUM_PORT), .ID_W(ID_W)) u_cell (
            .clk     (clk),
            .rst     (rst),
            .claim_v (claim_v),
            .rel_v   (rel_v),
            .req_id  (bus_mid),
            .owner_o (owner[s])
        );
    end

    hsem_ctrl #(.NUM_PORT(NUM_PORT), .CLR_W(CLR_W)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .ctrl_we  (ctrl_we),
        .ctrl_bit (ctrl_bit),
        .icr_we   (icr_we),
        .icr_mask (icr_mask),
        .proto_q  (proto_mode),
        .clr_q    (irq_clear)
    );

    assert_reset_clean_R9: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (proto_mode == 1'b0 && irq_clear == '0 && owner[0] == '0));
endmodule

// File: tb/sim_hsem_bank.sv
module sim_hsem_bank;
    localparam int NS = 32;
    localparam int NP = 2;

    logic                  clk = 1'b0;
    logic                  rst = 1'b1;
    logic [NP-1:0][7:0]    addr;
    logic [NP-1:0]         we;
    logic [NP-1:0][31:0]   wd;
    logic [NP-1:0][3:0]    mid;
    logic [NP-1:0][31:0]   rd;
    logic                  proto;
    logic [15:0]           clr;

    int    n_tests = 0;
    int    n_fail  = 0;
    bit    done    = 0;
    string cur_req = "R9";

    int m_own [NS];
    int m_ctrl;
    int m_clr;

    always #5 clk = ~clk;

    hsem_bank u0 (
        .clk(clk), .rst(rst), .bus_addr(addr), .bus_we(we), .bus_wdata(wd),
        .bus_mid(mid), .bus_rdata(rd), .proto_mode(proto), .irq_clear(clr)
    );

    function automatic int m_read(int a);
        if (a == 0) return m_ctrl;
        if (a >= 8 && a < 8 + 4 * NS && (a % 4) == 0) return m_own[(a - 8) / 4];
        return 0;
    endfunction

    function automatic int sem_of(int a);
        if (a >= 8 && a < 8 + 4 * NS && (a % 4) == 0) return (a - 8) / 4;
        return -1;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NS; s++) m_own[s] = 0;
        m_ctrl = 0;
        m_clr  = 0;
    endtask

    task automatic model_step();
        int nown [NS];
        int nctrl;
        int nclr;
        for (int s = 0; s < NS; s++) begin
            int best = 16;
            bit rel  = 0;
            nown[s] = m_own[s];
            for (int p = 0; p < NP; p++) begin
                if (we[p] && mid[p] != 0 && sem_of(int'(addr[p])) == s) begin
                    if (wd[p] == 0 && int'(mid[p]) == m_own[s]) rel = 1;
                    if (wd[p] != 0 && int'(mid[p]) < best) best = int'(mid[p]);
                end
            end
            if (m_own[s] != 0) begin
                if (rel) nown[s] = 0;
            end else if (best < 16) begin
                nown[s] = best;
            end
        end
        nctrl = m_ctrl;
        for (int p = NP - 1; p >= 0; p--)
            if (we[p] && addr[p] == 8'h00) nctrl = int'(wd[p][0]);
        nclr = 0;
        for (int p = 0; p < NP; p++)
            if (we[p] && addr[p] == 8'h90) nclr = nclr | int'(wd[p][15:0]);
        for (int s = 0; s < NS; s++) m_own[s] = nown[s];
        m_ctrl = nctrl;
        m_clr  = nclr;
    endtask

    task automatic check(string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", cur_req, what, act, exp);
        end
    endtask

    task automatic compare_all();
        for (int p = 0; p < NP; p++)
            check($sformatf("rdata port %0d addr 0x%0h", p, addr[p]), int'(rd[p]), m_read(int'(addr[p])));
        check("proto_mode", int'(proto), m_ctrl);
        check("irq_clear", int'(clr), m_clr);
    endtask

    // compare at negedge, then advance model and clock
    task automatic step();
        @(negedge clk);
        compare_all();
        if (rst) model_reset(); else model_step();
        @(posedge clk);
        #1;
    endtask

    task automatic set_port(int p, int a, bit w, int d, int m);
        addr[p] = 8'(a);
        we[p]   = w;
        wd[p]   = 32'(d);
        mid[p]  = 4'(m);
    endtask

    task automatic idle();
        for (int p = 0; p < NP; p++) set_port(p, 0, 0, 0, 0);
    endtask

    task automatic rd_both(int a0, int a1);
        idle();
        set_port(0, a0, 0, 0, 0);
        set_port(1, a1, 0, 0, 0);
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        idle();
        model_reset();
        rst = 1'b1;
        step();
        step();
        rst = 1'b0;

        // R9: reset state
        cur_req = "R9";
        rd_both(8'h00, 8'h08);
        rd_both(8'h84, 8'h90);

        // R1: all semaphore offsets read free
        cur_req = "R1";
        for (int s = 0; s < NS; s += 2) rd_both(8 + 4 * s, 8 + 4 * (s + 1));

        // R2: claim sem 5 by id 3, then read back from the other port
        cur_req = "R2";
        idle(); set_port(0, 8 + 4 * 5, 1, 3, 3); step();
        rd_both(8 + 4 * 5, 8 + 4 * 5);
        idle(); set_port(1, 8 + 4 * 31, 1, 32'hFFFF_FFF0, 9); step();
        rd_both(8 + 4 * 31, 8 + 4 * 5);

        // R12: write and read in same cycle shows old value
        cur_req = "R12";
        idle(); set_port(0, 8 + 4 * 3, 1, 4, 4); set_port(1, 8 + 4 * 3, 0, 0, 0); step();
        rd_both(8 + 4 * 3, 8 + 4 * 3);

        // R3: takeover attempts and re-claim by owner
        cur_req = "R3";
        idle(); set_port(1, 8 + 4 * 5, 1, 7, 7); step();
        idle(); set_port(0, 8 + 4 * 5, 1, 1, 3); step();
        rd_both(8 + 4 * 5, 8 + 4 * 5);

        // R4: release by non-owner ignored, by owner accepted
        cur_req = "R4";
        idle(); set_port(1, 8 + 4 * 5, 1, 0, 7); step();
        rd_both(8 + 4 * 5, 0);
        idle(); set_port(0, 8 + 4 * 5, 1, 0, 3); step();
        rd_both(8 + 4 * 5, 8 + 4 * 5);

        // R6: identity 0 ignored
        cur_req = "R6";
        idle(); set_port(0, 8 + 4 * 7, 1, 5, 0); step();
        rd_both(8 + 4 * 7, 8 + 4 * 7);
        idle(); set_port(1, 8 + 4 * 31, 1, 0, 0); step();
        rd_both(8 + 4 * 31, 8 + 4 * 31);

        // R5: simultaneous claims, higher id on port 0
        cur_req = "R5";
        idle(); set_port(0, 8 + 4 * 9, 1, 6, 6); set_port(1, 8 + 4 * 9, 1, 2, 2); step();
        rd_both(8 + 4 * 9, 8 + 4 * 9);
        idle(); set_port(0, 8 + 4 * 10, 1, 1, 1); set_port(1, 8 + 4 * 10, 1, 8, 8); step();
        rd_both(8 + 4 * 10, 8 + 4 * 10);

        // R11: owner releases while another claims
        cur_req = "R11";
        idle(); set_port(0, 8 + 4 * 9, 1, 5, 5); set_port(1, 8 + 4 * 9, 1, 0, 2); step();
        rd_both(8 + 4 * 9, 8 + 4 * 9);

        // R7: control register
        cur_req = "R7";
        idle(); set_port(0, 0, 1, 32'hFFFF_FFFF, 1); step();
        rd_both(0, 0);
        idle(); set_port(0, 0, 1, 0, 1); set_port(1, 0, 1, 1, 2); step();
        rd_both(0, 8 + 4 * 10);
        idle(); set_port(1, 0, 1, 1, 2); step();
        rd_both(0, 0);

        // R8: clear strobe
        cur_req = "R8";
        idle(); set_port(0, 8'h90, 1, 32'hFFFF, 1); step();
        rd_both(8'h90, 8'h90);
        idle(); set_port(0, 8'h90, 1, 32'h0101, 1); set_port(1, 8'h90, 1, 32'h8000, 2); step();
        step();

        // R10: unmapped and misaligned offsets
        cur_req = "R10";
        idle(); set_port(0, 8'h04, 1, 32'hFF, 3); set_port(1, 8'h09, 1, 4, 4); step();
        idle(); set_port(0, 8'h88, 1, 5, 5); set_port(1, 8'hFC, 1, 1, 1); step();
        rd_both(8'h04, 8'h09);
        rd_both(8'h88, 8'h08);
        rd_both(8'h0C, 0);

        // random collisions over a narrow address set
        cur_req = "R5/R11 random";
        for (int i = 0; i < 3000; i++) begin
            for (int p = 0; p < NP; p++) begin
                int sel = int'($urandom % 10);
                int a;
                int m = int'($urandom % 5);
                int d;
                case (sel)
                    0: a = 0;
                    1: a = 8'h90;
                    2: a = 8'h88;
                    3: a = 8'h0A;
                    default: a = 8 + 4 * (sel - 4);
                endcase
                case ($urandom % 3)
                    0: d = 0;
                    1: d = m;
                    default: d = int'($urandom);
                endcase
                set_port(p, a, 1'($urandom % 2), d, m);
            end
            step();
        end

        idle();
        step();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule